// File: doc/BRIEF.md
# Continuous-Read Serial Port Model for a Sigma-Delta Converter

This block is a synthesizable model of the device side of a converter's serial port, meant for testbenches and emulation platforms. An internal source pushes conversion results into it. The model numbers each result with the next enabled channel, taken in cyclic order. A host drives chip select, a serial clock and a data-in line. The model decodes command bytes from that data-in line. One command puts the port into continuous read. In that mode every new result is announced by the shared data-out/ready line going low, and the host clocks the result out MSB first.

While a word is waiting, the model keeps listening on data-in for the exit command. It also counts a run of consecutive ones, which resets the whole interface. A mode-register write can switch on a status byte after each data word; that byte names the channel of the conversion. All port lines are oversampled by the system clock. The serial clock idles high. The model samples data-in on serial-clock rising edges and changes data-out on falling edges.

Top module: `cr_serial_port`

## Requirements
- R1: After reset the port is out of continuous read and status append is off. With cs_n low, dout is 1, and pushed results leave dout at 1.
- R2: The command byte 0x5C, sent MSB first on din outside continuous read, enters continuous read. Each result pushed in that mode drives dout to 0 within two clock cycles.
- R3: Each falling edge of sclk presents the next bit of the waiting word, MSB first. The word is 24 data bits, or 32 bits with status append. On the sclk rising edge after the last bit, dout returns to 1 and stays 1 until the next result.
- R4: A result pushed before the waiting word has been fully read replaces it. dout is 0 again and the next read-out delivers the new word from its MSB.
- R5: The byte 0x58, received in continuous read while a word is waiting, leaves the mode. dout goes to 1 and later results are ignored. A 0x58 received with no word waiting is ignored.
- R6: Forty consecutive 1 bits sampled on din reset the interface. The reset leaves continuous read, clears status append and restarts the channel order. A run of 39 ones followed by a 0 has no effect.
- R7: A command byte 0x08 followed by 24 mode bits, MSB first, sets status append from mode bit 20. With status append on, the status byte follows the data word. Its upper bits are zero and its low two bits hold the channel number.
- R8: Results take channels in cyclic ascending order over the set bits of chan_en, starting with the lowest enabled channel after reset. With no channel enabled, the result takes channel 0.
- R9: cs_n high makes dout_en 0 and clears the bit counters, but keeps the mode. When cs_n returns low, a waiting word reads out again from its MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle high |
| din | input | 1 | Serial command and data input |
| dout | output | 1 | Serial data out, doubling as the ready flag |
| dout_en | output | 1 | Output enable for dout, high while selected |
| conv_valid | input | 1 | One-cycle push of a new conversion result |
| conv_data | input | 24 | Conversion result |
| chan_en | input | 4 | Enabled-channel mask for the cyclic order |

## Verification
A wrong mode flag shows at once: dout stays high after a push when it should fall, or falls when the port should ignore the push. A bit counter that is off shows at the first read-out as a shifted or truncated word, or as dout failing to return high right after the last bit. A wrong channel pointer or a stale append flag shows up in the trailing status byte of the very next word. A ones counter that misses a zero shows up as a spurious exit from continuous read after a near-miss run.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam logic [7:0] CMD_ENTER_CREAD = 8'h5C;
  localparam logic [7:0] CMD_EXIT_CREAD  = 8'h58;
  localparam logic [7:0] CMD_WRITE_MODE  = 8'h08;

  typedef enum logic {
    DEC_CMD,
    DEC_MODE
  } dec_state_e;
endpackage

// File: rtl/cr_cmd_decoder.sv
module cr_cmd_decoder
  import cr_pkg::*;
#(
  parameter int MODE_W     = 24,
  parameter int STA_POS    = 20,
  parameter int ONES_LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk_rise,
  input  logic din_bit,
  input  logic in_cread,
  input  logic word_ready,
  output logic enter_cmd,
  output logic exit_cmd,
  output logic sta_wr,
  output logic sta_val,
  output logic ones_rst
);
  localparam int CNT_W   = $clog2(MODE_W);
  localparam int ONES_W  = $clog2(ONES_LIMIT + 1);
  localparam int CAP_IDX = MODE_W - 1 - STA_POS;

  dec_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [6:0]        sh_q, sh_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic              cap_q, cap_d;
  logic [7:0]        byte_w;

  assign byte_w = {sh_q, din_bit};

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    ones_d    = ones_q;
    cap_d     = cap_q;
    enter_cmd = 1'b0;
    exit_cmd  = 1'b0;
    sta_wr    = 1'b0;
    sta_val   = cap_q;
    ones_rst  = 1'b0;
    if (cs_n) begin
      cnt_d   = '0;
      state_d = DEC_CMD;
      ones_d  = '0;
    end else if (sclk_rise) begin
      sh_d   = byte_w[6:0];
      ones_d = din_bit ? ones_q + 1'b1 : '0;
      if (din_bit && ones_q == ONES_W'(ONES_LIMIT - 1)) begin
        ones_rst = 1'b1;
        ones_d   = '0;
        cnt_d    = '0;
        state_d  = DEC_CMD;
      end else begin
        case (state_q)
          DEC_CMD: begin
            if (cnt_q == CNT_W'(7)) begin
              cnt_d = '0;
              if (in_cread) begin
                if (byte_w == CMD_EXIT_CREAD && word_ready) exit_cmd = 1'b1;
              end else if (byte_w == CMD_ENTER_CREAD) begin
                enter_cmd = 1'b1;
              end else if (byte_w == CMD_WRITE_MODE) begin
                state_d = DEC_MODE;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: begin
            if (cnt_q == CNT_W'(CAP_IDX)) cap_d = din_bit;
            if (cnt_q == CNT_W'(MODE_W - 1)) begin
              sta_wr  = 1'b1;
              sta_val = (cnt_q == CNT_W'(CAP_IDX)) ? din_bit : cap_q;
              cnt_d   = '0;
              state_d = DEC_CMD;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DEC_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      ones_q  <= '0;
      cap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ones_q  <= ones_d;
      cap_q   <= cap_d;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_cmd, exit_cmd, sta_wr, ones_rst})); // R6
  AST_CS_CLEARS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ones_q == '0); // R9
endmodule

// File: rtl/cr_chan_seq.sv
module cr_chan_seq #(
  parameter int NCH  = 4,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [NCH-1:0]  chan_en,
  output logic [CH_W-1:0] chan_next
);
  logic [CH_W-1:0] last_q, last_d;
  logic            found;

  always_comb begin
    chan_next = '0;
    found     = 1'b0;
    for (int i = 1; i <= NCH; i++) begin
      int idx;
      idx = (int'(last_q) + i) % NCH;
      if (!found && chan_en[idx]) begin
        chan_next = CH_W'(idx);
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (clr)      last_d = CH_W'(NCH - 1);
    else if (adv) last_d = chan_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= CH_W'(NCH - 1);
    else        last_q <= last_d;
  end

  AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && |chan_en) |-> chan_en[chan_next]); // R8
  AST_CHAN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && $countones(chan_en) > 1) |=> last_q != $past(last_q)); // R8
endmodule

// File: rtl/cr_dout_shifter.sv
module cr_dout_shifter #(
  parameter int DATA_W = 24,
  parameter int STA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [STA_W-1:0]  load_sta,
  input  logic              append,
  input  logic              cs_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  output logic              dout,
  output logic              ready
);
  localparam int TOT   = DATA_W + STA_W;
  localparam int CNT_W = $clog2(TOT + 1);
  localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(TOT);
  localparam logic [CNT_W-1:0] LEN_DATA = CNT_W'(DATA_W);

  logic [TOT-1:0]   word_q, word_d;
  logic [TOT-1:0]   sh_q, sh_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic [CNT_W-1:0] len_w;
  logic             app_q, app_d;
  logic             ready_q, ready_d;
  logic             dout_q, dout_d;

  assign len_w = app_q ? LEN_FULL : LEN_DATA;

  always_comb begin
    word_d  = word_q;
    sh_d    = sh_q;
    bcnt_d  = bcnt_q;
    app_d   = app_q;
    ready_d = ready_q;
    dout_d  = dout_q;
    if (clr) begin
      ready_d = 1'b0;
      bcnt_d  = '0;
      dout_d  = 1'b1;
    end else if (load) begin
      word_d  = append ? {load_data, load_sta} : {load_data, {STA_W{1'b0}}};
      sh_d    = word_d;
      app_d   = append;
      ready_d = 1'b1;
      bcnt_d  = '0;
      dout_d  = 1'b0;
    end else if (cs_n) begin
      bcnt_d = '0;
      sh_d   = word_q;
      dout_d = ~ready_q;
    end else if (ready_q) begin
      if (sclk_fall && bcnt_q < len_w) begin
        dout_d = sh_q[TOT-1];
        sh_d   = {sh_q[TOT-2:0], 1'b0};
        bcnt_d = bcnt_q + 1'b1;
      end else if (sclk_rise && bcnt_q == len_w) begin
        ready_d = 1'b0;
        dout_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      sh_q    <= '0;
      bcnt_q  <= '0;
      app_q   <= 1'b0;
      ready_q <= 1'b0;
      dout_q  <= 1'b1;
    end else begin
      word_q  <= word_d;
      sh_q    <= sh_d;
      bcnt_q  <= bcnt_d;
      app_q   <= app_d;
      ready_q <= ready_d;
      dout_q  <= dout_d;
    end
  end

  assign dout  = dout_q;
  assign ready = ready_q;

  AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (ready_q && !dout_q)); // R2
  AST_BCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= LEN_FULL); // R3
  AST_DONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_q) |-> dout_q); // R3
  AST_CS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> bcnt_q == '0); // R9
endmodule

// File: rtl/cr_serial_port.sv
module cr_serial_port
  import cr_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int NCH        = 4,
  parameter int MODE_W     = 24,
  parameter int STA_POS    = 20,
  parameter int ONES_LIMIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [NCH-1:0]    chan_en
);
  localparam int STA_W = 8;
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;

  logic [1:0]      rst_pipe;
  logic            srst_n;
  logic            cs_q, sclk_q, sclk_q2, din_q;
  logic            sclk_rise, sclk_fall;
  logic            cread_q, cread_d;
  logic            sta_app_q, sta_app_d;
  logic            enter_cmd, exit_cmd, sta_wr, sta_val, ones_rst;
  logic            word_ready, shift_dout;
  logic            shift_clr, shift_load;
  logic [CH_W-1:0] chan_next;
  logic [STA_W-1:0] sta_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      sclk_q2 <= 1'b1;
      din_q   <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      sclk_q  <= sclk;
      sclk_q2 <= sclk_q;
      din_q   <= din;
    end
  end

  assign sclk_rise = sclk_q & ~sclk_q2;
  assign sclk_fall = ~sclk_q & sclk_q2;

  cr_cmd_decoder #(
    .MODE_W    (MODE_W),
    .STA_POS   (STA_POS),
    .ONES_LIMIT(ONES_LIMIT)
  ) i_dec (
    .clk       (clk),
    .rst_n     (srst_n),
    .cs_n      (cs_q),
    .sclk_rise (sclk_rise),
    .din_bit   (din_q),
    .in_cread  (cread_q),
    .word_ready(word_ready),
    .enter_cmd (enter_cmd),
    .exit_cmd  (exit_cmd),
    .sta_wr    (sta_wr),
    .sta_val   (sta_val),
    .ones_rst  (ones_rst)
  );

  cr_chan_seq #(
    .NCH (NCH),
    .CH_W(CH_W)
  ) i_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr      (ones_rst),
    .adv      (conv_valid),
    .chan_en  (chan_en),
    .chan_next(chan_next)
  );

  always_comb begin
    sta_byte              = '0;
    sta_byte[CH_W-1:0]    = chan_next;
  end

  always_comb begin
    cread_d   = cread_q;
    sta_app_d = sta_app_q;
    if (ones_rst) begin
      cread_d   = 1'b0;
      sta_app_d = 1'b0;
    end else begin
      if (exit_cmd)  cread_d = 1'b0;
      if (enter_cmd) cread_d = 1'b1;
      if (sta_wr)    sta_app_d = sta_val;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cread_q   <= 1'b0;
      sta_app_q <= 1'b0;
    end else begin
      cread_q   <= cread_d;
      sta_app_q <= sta_app_d;
    end
  end

  assign shift_clr  = ones_rst | exit_cmd | enter_cmd;
  assign shift_load = conv_valid & cread_q;

  cr_dout_shifter #(
    .DATA_W(DATA_W),
    .STA_W (STA_W)
  ) i_shift (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr      (shift_clr),
    .load     (shift_load),
    .load_data(conv_data),
    .load_sta (sta_byte),
    .append   (sta_app_q),
    .cs_n     (cs_q),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .dout     (shift_dout),
    .ready    (word_ready)
  );

  assign dout    = cread_q ? shift_dout : 1'b1;
  assign dout_en = ~cs_n;

  AST_ENTER_SETS: assert property (@(posedge clk) disable iff (!srst_n)
    (enter_cmd && !ones_rst) |=> cread_q); // R2
  AST_EXIT_LEAVES: assert property (@(posedge clk) disable iff (!srst_n)
    exit_cmd |=> !cread_q); // R5
  AST_ONES_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    ones_rst |=> (!cread_q && !sta_app_q)); // R6
  AST_READY_IN_CREAD: assert property (@(posedge clk) disable iff (!srst_n)
    !cread_q |-> !word_ready); // R5
endmodule

// File: tb/test_cr_serial_port.sv
module test_cr_serial_port;
  localparam int DATA_W = 24;
  localparam int NCH    = 4;

  logic              clk = 1'b0;
  logic              rst_n, cs_n, sclk, din, conv_valid;
  logic [DATA_W-1:0] conv_data;
  logic [NCH-1:0]    chan_en;
  logic              dout, dout_en;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  int m_last = NCH - 1;
  bit m_cread = 1'b0;
  bit m_app = 1'b0;

  always #5 clk = ~clk;

  cr_serial_port i_cr_serial_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .din       (din),
    .dout      (dout),
    .dout_en   (dout_en),
    .conv_valid(conv_valid),
    .conv_data (conv_data),
    .chan_en   (chan_en)
  );

  function automatic int next_ch(int last, logic [NCH-1:0] en);
    for (int i = 1; i <= NCH; i++) begin
      if (en[(last + i) % NCH]) return (last + i) % NCH;
    end
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    @(negedge clk);
    sclk = 1'b0;
    din  = b;
    repeat (4) @(negedge clk);
    r    = dout;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic r;
    for (int i = n - 1; i >= 0; i--) xfer_bit(v[i], r);
    din = 1'b0;
  endtask

  // driver: pushes a result and records what the port should deliver
  task automatic push(input logic [DATA_W-1:0] d);
    int ch;
    @(negedge clk);
    conv_data  = d;
    conv_valid = 1'b1;
    ch = next_ch(m_last, chan_en);
    m_last = ch;
    if (m_cread) begin
      exp_q.delete();
      exp_q.push_back(m_app ? {d, 8'(ch)} : {8'h00, d});
    end
    @(negedge clk);
    conv_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: clocks out one word and compares it against the oldest entry
  task automatic read_cmp(string req);
    logic [31:0] w;
    logic [31:0] e;
    logic r;
    int n;
    n = m_app ? 32 : 24;
    w = '0;
    for (int i = 0; i < n; i++) begin
      xfer_bit(1'b0, r);
      w = {w[30:0], r};
    end
    if (exp_q.size() == 0) begin
      check(req, w, 32'hxxxxxxxx);
    end else begin
      e = exp_q.pop_front();
      check(req, w, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic r;
    rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b1; din = 1'b0;
    conv_valid = 1'b0; conv_data = '0; chan_en = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    check("R1 idle dout", {31'd0, dout}, 32'd1);
    check("R9 dout_en selected", {31'd0, dout_en}, 32'd1);
    push(24'h111111);
    check("R1 push ignored outside mode", {31'd0, dout}, 32'd1);

    send_bits(32'h5C, 8); m_cread = 1'b1;
    check("R2 enter without word", {31'd0, dout}, 32'd1);
    push(24'hA5C3F1);
    check("R2 ready low", {31'd0, dout}, 32'd0);
    read_cmp("R3 word");
    check("R3 high after word", {31'd0, dout}, 32'd1);
    repeat (20) @(negedge clk);
    check("R3 stays high", {31'd0, dout}, 32'd1);

    push(24'h0F0F0F);
    for (int i = 0; i < 8; i++) xfer_bit(1'b0, r);
    push(24'h9ABCDE);
    check("R4 ready after overwrite", {31'd0, dout}, 32'd0);
    read_cmp("R4 new word");

    send_bits(32'h58, 8);
    push(24'h123456);
    check("R5 exit ignored without word", {31'd0, dout}, 32'd0);
    read_cmp("R5 still reading");

    push(24'h654321);
    send_bits(32'h58, 8);
    exp_q.delete(); m_cread = 1'b0;
    check("R5 exit dout high", {31'd0, dout}, 32'd1);
    push(24'hFEDCBA);
    check("R5 push ignored after exit", {31'd0, dout}, 32'd1);

    send_bits(32'h08, 8);
    send_bits(32'h100000, 24); m_app = 1'b1;
    send_bits(32'h5C, 8); m_cread = 1'b1;
    chan_en = 4'b1010;
    push(24'h13579B);
    read_cmp("R7 status appended");
    push(24'h2468AC);
    read_cmp("R8 cyclic wrap");
    push(24'h0A0B0C);
    read_cmp("R8 cyclic next");
    chan_en = 4'b0000;
    push(24'h777777);
    read_cmp("R8 none enabled");
    chan_en = 4'hF;

    push(24'hC0FFEE);
    for (int i = 0; i < 10; i++) xfer_bit(1'b0, r);
    @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 dout_en off", {31'd0, dout_en}, 32'd0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 ready kept", {31'd0, dout}, 32'd0);
    read_cmp("R9 restart from MSB");

    for (int i = 0; i < 39; i++) xfer_bit(1'b1, r);
    xfer_bit(1'b0, r); din = 1'b0;
    push(24'h55AA55);
    check("R6 near miss keeps mode", {31'd0, dout}, 32'd0);
    read_cmp("R6 near miss word");

    for (int i = 0; i < 40; i++) xfer_bit(1'b1, r);
    din = 1'b0;
    m_cread = 1'b0; m_app = 1'b0; m_last = NCH - 1;
    push(24'h3C3C3C);
    check("R6 reset leaves mode", {31'd0, dout}, 32'd1);
    send_bits(32'h5C, 8); m_cread = 1'b1;
    push(24'hBEEF01);
    read_cmp("R6 append cleared");
    check("R6 word ends at 24 bits", {31'd0, dout}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule